// File: doc/BRIEF.md
# Configurable Carry-Mode ALU Slice

This block is one 8-bit arithmetic/logic slice. Each cycle a 3-bit function code and a 2-bit carry-select code arrive together, as if read from a per-cycle control word. The function code selects pass, increment, decrement, add, subtract, XOR, AND or OR on two operands. The carry-select code selects where the carry for arithmetic comes from: a per-function default, the slice's own carry flag from the previous cycle, an external routed line, or the carry-out of a lower slice in a cascade.

The carry-out is taken from a bit position that is set statically. It leaves the slice combinationally, so two slices can be wired into one 16-bit adder or subtractor that finishes in a single cycle. The carry-out is also captured every cycle in a carry flag. That flag lets a wide sum or difference be built over several cycles in one slice. The 8-bit result is ANDed with a static mask before it leaves the block, which allows counters that wrap at a power of two.

Top module: `cfg_alu_slice`

## Requirements
- R1: `func_i` encodes 000 pass `a_i`, 101 `a_i ^ b_i`, 110 `a_i & b_i`, 111 `a_i | b_i`; the arithmetic codes are 001 increment, 010 decrement, 011 add, 100 subtract.
- R2: With `csel_i` = 00, increment gives a+1, decrement gives a-1, add gives a+b and subtract gives a-b, all modulo 256.
- R3: `csel_i` picks the carry: 00 per-function default, 01 the carry flag `cflag_o`, 10 `route_ci_i`, 11 `chain_ci_i`.
- R4: When a selected carry c is 1, increment and add produce one more than without it (a+c, a+b+c). Decrement and subtract are active on the same set level and produce a-c and a-b-c. The default carry is 1 for increment and decrement and 0 for add and subtract.
- R5: With `msb_sel_i` = p, `co_o` is the carry out of bits p..0 of the operation. For increment and add it is 1 when (a mod 2^(p+1)) + operand + c reaches 2^(p+1). For decrement and subtract it is a borrow, 1 when (a mod 2^(p+1)) - operand - c is negative.
- R6: Pass, XOR, AND and OR drive `co_o` to 0.
- R7: `res_o` equals the 8-bit function result ANDed bitwise with `mask_i`; the mask does not affect `co_o`.
- R8: On every rising clock edge `cflag_o` takes the value `co_o` had in that cycle, including 0 after a logic function. While `rst_ni` is low, `cflag_o` is 0.
- R9: `co_o` is combinational from the same cycle's inputs. A lower slice doing add or subtract with carry-select 00 and p = 7, feeding an upper slice with carry-select 11, yields the 16-bit sum or difference in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| func_i | input | 3 | Function code |
| csel_i | input | 2 | Carry-select code |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| route_ci_i | input | 1 | Externally routed carry-in |
| chain_ci_i | input | 1 | Carry-in from the lower slice |
| msb_sel_i | input | 3 | Bit position that generates carry-out |
| mask_i | input | 8 | Static AND mask on the result |
| res_o | output | 8 | Masked result |
| co_o | output | 1 | Carry-out, also the chain output |
| cflag_o | output | 1 | Registered carry flag |

## Verification
Two functions meet in the same cycle when the registered-carry mode is selected: the operation reads the carry flag, and at the next edge the same operation's carry-out overwrites that flag. The bench provokes this with back-to-back registered-carry operations in both directed sequences (a 16-bit add and a 16-bit subtract split over two cycles) and random runs. It judges each result against a model that holds its own carry flag and updates it from its own predicted carry-out. Random values of the MSB position and the mask are mixed in, so the borrow sense and the masking are tested against the same flag traffic.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;
  typedef enum logic [2:0] {
    FN_PASS = 3'b000,
    FN_INC  = 3'b001,
    FN_DEC  = 3'b010,
    FN_ADD  = 3'b011,
    FN_SUB  = 3'b100,
    FN_XOR  = 3'b101,
    FN_AND  = 3'b110,
    FN_OR   = 3'b111
  } alu_func_e;

  typedef enum logic [1:0] {
    CS_DEFAULT = 2'b00,
    CS_FLAG    = 2'b01,
    CS_ROUTE   = 2'b10,
    CS_CHAIN   = 2'b11
  } carry_sel_e;
endpackage

// File: rtl/alu_slice_cin.sv
module alu_slice_cin
  import alu_slice_pkg::*;
(
  input  logic [2:0] func_i,
  input  logic [1:0] csel_i,
  input  logic       flag_i,
  input  logic       route_i,
  input  logic       chain_i,
  output logic       cin_o   // logical carry: 1 = one extra step
);
  always_comb begin
    case (csel_i)
      CS_FLAG:  cin_o = flag_i;
      CS_ROUTE: cin_o = route_i;
      CS_CHAIN: cin_o = chain_i;
      default:  cin_o = (func_i == FN_INC) || (func_i == FN_DEC);
    endcase
  end
endmodule

// File: rtl/alu_slice_core.sv
module alu_slice_core
  import alu_slice_pkg::*;
#(
  parameter int W  = 8,
  parameter int SW = $clog2(W)
) (
  input  logic [2:0]    func_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          cin_i,
  input  logic [SW-1:0] msb_i,
  output logic [W-1:0]  res_o,
  output logic          co_o
);
  logic [W-1:0] opb, keep;
  logic [W:0]   sum, low;
  logic         ci_eff, add_like, sub_like, raw_c;

  always_comb begin
    add_like = (func_i == FN_INC) || (func_i == FN_ADD);
    sub_like = (func_i == FN_DEC) || (func_i == FN_SUB);
    case (func_i)
      FN_INC:  opb = '0;
      FN_DEC:  opb = '1;
      FN_ADD:  opb = b_i;
      default: opb = ~b_i;
    endcase
    // borrow-type functions take the carry inverted
    ci_eff = sub_like ? ~cin_i : cin_i;
    for (int i = 0; i < W; i++) keep[i] = (i <= int'(msb_i));
    sum   = {1'b0, a_i} + {1'b0, opb} + {{W{1'b0}}, ci_eff};
    low   = {1'b0, a_i & keep} + {1'b0, opb & keep} + {{W{1'b0}}, ci_eff};
    // only bit p+1 of the truncated sum can lie outside keep
    raw_c = |(low & ~{1'b0, keep});
    case (func_i)
      FN_PASS: res_o = a_i;
      FN_XOR:  res_o = a_i ^ b_i;
      FN_AND:  res_o = a_i & b_i;
      FN_OR:   res_o = a_i | b_i;
      default: res_o = sum[W-1:0];
    endcase
    co_o = add_like ? raw_c : (sub_like ? ~raw_c : 1'b0);
  end
endmodule

// File: rtl/cfg_alu_slice.sv
module cfg_alu_slice
  import alu_slice_pkg::*;
#(
  parameter int W  = 8,
  localparam int SW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    func_i,
  input  logic [1:0]    csel_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          route_ci_i,
  input  logic          chain_ci_i,
  input  logic [SW-1:0] msb_sel_i,
  input  logic [W-1:0]  mask_i,
  output logic [W-1:0]  res_o,
  output logic          co_o,
  output logic          cflag_o
);
  logic         flag_q, cin, co_w;
  logic [W-1:0] core_res;

  alu_slice_cin u_cin (
    .func_i  (func_i),
    .csel_i  (csel_i),
    .flag_i  (flag_q),
    .route_i (route_ci_i),
    .chain_i (chain_ci_i),
    .cin_o   (cin)
  );

  alu_slice_core #(.W(W)) u_core (
    .func_i (func_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin),
    .msb_i  (msb_sel_i),
    .res_o  (core_res),
    .co_o   (co_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= co_w;
  end

  assign res_o   = core_res & mask_i;
  assign co_o    = co_w;
  assign cflag_o = flag_q;
endmodule

// File: rtl/cfg_alu_slice_chk.sv
module cfg_alu_slice_chk #(
  parameter int W  = 8,
  parameter int SW = $clog2(W)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    func_i,
  input logic [1:0]    csel_i,
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  mask_i,
  input logic [SW-1:0] msb_sel_i,
  input logic [W-1:0]  res_o,
  input logic          co_o,
  input logic          cflag_o
);
  logic live;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live <= 1'b0;
    else         live <= 1'b1;
  end

  a_r8_flag_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> (cflag_o == $past(co_o)));

  a_r6_logic_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_i == 3'b000 || func_i == 3'b101 || func_i == 3'b110 || func_i == 3'b111) |-> !co_o);

  a_r7_mask_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o & ~mask_i) == '0);

  a_r1_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_i == 3'b000) |-> (res_o == (a_i & mask_i)));

  a_r3_flag_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_i == 3'b001 && csel_i == 2'b01 && mask_i == '1 && msb_sel_i == SW'(W-1))
      |-> (res_o == W'(a_i + W'(cflag_o))));
endmodule

bind cfg_alu_slice cfg_alu_slice_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .func_i    (func_i),
  .csel_i    (csel_i),
  .a_i       (a_i),
  .mask_i    (mask_i),
  .msb_sel_i (msb_sel_i),
  .res_o     (res_o),
  .co_o      (co_o),
  .cflag_o   (cflag_o)
);

// File: tb/tb_cfg_alu_slice.sv
`timescale 1ns/1ps
module tb_cfg_alu_slice;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] func = '0;
  logic [1:0] csel = '0;
  logic [7:0] a = '0, b = '0, mask = 8'hFF;
  logic       rc = 1'b0, cc = 1'b0;
  logic [2:0] msb = 3'd7;
  logic [7:0] res;
  logic       co, cflag;

  logic [2:0] h_func = '0;
  logic [1:0] h_csel = 2'b11;
  logic [7:0] h_a = '0, h_b = '0;
  logic [7:0] h_res;
  logic       h_co, h_flag;

  int errors = 0, checks = 0;
  logic exp_flag = 1'b0;

  always #2 clk = ~clk;

  cfg_alu_slice dut (
    .clk_i(clk), .rst_ni(rst_n), .func_i(func), .csel_i(csel), .a_i(a), .b_i(b),
    .route_ci_i(rc), .chain_ci_i(cc), .msb_sel_i(msb), .mask_i(mask),
    .res_o(res), .co_o(co), .cflag_o(cflag)
  );

  cfg_alu_slice dut_hi (
    .clk_i(clk), .rst_ni(rst_n), .func_i(h_func), .csel_i(h_csel), .a_i(h_a), .b_i(h_b),
    .route_ci_i(1'b0), .chain_ci_i(co), .msb_sel_i(3'd7), .mask_i(8'hFF),
    .res_o(h_res), .co_o(h_co), .cflag_o(h_flag)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: returns {carry_out, masked result}
  function automatic logic [8:0] model(int f, int cs, int av, int bv, int r, int ch,
                                       int fl, int mk, int p);
    int c, m, rv, cov;
    m = 1 << (p + 1);
    case (cs)
      1: c = fl;
      2: c = r;
      3: c = ch;
      default: c = (f == 1 || f == 2) ? 1 : 0;
    endcase
    case (f)
      1: begin rv = av + c;      cov = ((av % m) + c) >= m ? 1 : 0; end
      2: begin rv = av - c;      cov = ((av % m) - c) < 0 ? 1 : 0; end
      3: begin rv = av + bv + c; cov = ((av % m) + (bv % m) + c) >= m ? 1 : 0; end
      4: begin rv = av - bv - c; cov = ((av % m) - (bv % m) - c) < 0 ? 1 : 0; end
      5: begin rv = av ^ bv; cov = 0; end
      6: begin rv = av & bv; cov = 0; end
      7: begin rv = av | bv; cov = 0; end
      default: begin rv = av; cov = 0; end
    endcase
    rv = rv & 255 & mk;
    return {cov[0], rv[7:0]};
  endfunction

  task automatic step(string tag, int f, int cs, int av, int bv, int r, int ch, int mk, int p);
    logic [8:0] e;
    @(negedge clk);
    func = f[2:0]; csel = cs[1:0]; a = av[7:0]; b = bv[7:0];
    rc = r[0]; cc = ch[0]; mask = mk[7:0]; msb = p[2:0];
    #1;
    e = model(f, cs, av, bv, r, ch, int'(exp_flag), mk, p);
    check({tag, " res"}, int'(res), int'(e[7:0]));
    check({tag, " co"}, int'(co), int'(e[8]));
    check("R8 flag", int'(cflag), int'(exp_flag));
    exp_flag = e[8];
  endtask

  task automatic cascade(string tag, int f, int x, int y);
    int s;
    @(negedge clk);
    func = f[2:0]; csel = 2'b00; msb = 3'd7; mask = 8'hFF;
    a = x[7:0]; b = y[7:0]; h_func = f[2:0]; h_a = x[15:8]; h_b = y[15:8];
    #1;
    s = (f == 3) ? (x + y) : (x - y);
    check({tag, " R9 16b"}, int'({h_res, res}), s & 16'hFFFF);
    check({tag, " R9 top co"}, int'(h_co), (f == 3) ? ((x + y) >> 16) & 1 : (x < y ? 1 : 0));
    exp_flag = co;
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    check("R8 reset flag", int'(cflag), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 logic functions and pass, R6 no carry
    step("R1 pass", 0, 0, 8'hA5, 8'h3C, 0, 0, 8'hFF, 7);
    step("R1 xor",  5, 0, 8'hA5, 8'h3C, 1, 1, 8'hFF, 7);
    step("R1 and",  6, 0, 8'hA5, 8'h3C, 0, 0, 8'hFF, 7);
    step("R6 or",   7, 0, 8'hFF, 8'hFF, 0, 0, 8'hFF, 0);
    // R2 defaults and wrap
    step("R2 inc wrap", 1, 0, 8'hFF, 0, 0, 0, 8'hFF, 7);
    step("R2 dec zero", 2, 0, 8'h00, 0, 0, 0, 8'hFF, 7);
    step("R2 add",      3, 0, 8'hC8, 8'h64, 0, 0, 8'hFF, 7);
    step("R2 sub",      4, 0, 8'h10, 8'h20, 0, 0, 8'hFF, 7);
    // R4 routed polarity
    step("R4 inc rc0", 1, 2, 8'h10, 0, 0, 0, 8'hFF, 7);
    step("R4 dec rc1", 2, 2, 8'h10, 0, 1, 0, 8'hFF, 7);
    step("R4 dec rc0", 2, 2, 8'h10, 0, 0, 0, 8'hFF, 7);
    step("R4 sub rc1", 4, 2, 8'h50, 8'h20, 1, 0, 8'hFF, 7);
    step("R3 chain add", 3, 3, 8'h01, 8'h01, 0, 1, 8'hFF, 7);
    // R5 narrowed MSB position
    step("R5 add p3",  3, 0, 8'h0F, 8'h01, 0, 0, 8'hFF, 3);
    step("R5 sub p3",  4, 0, 8'h30, 8'h01, 0, 0, 8'hFF, 3);
    step("R5 inc p0",  1, 0, 8'h01, 0, 0, 0, 8'hFF, 0);
    // R7 mask
    step("R7 mask", 3, 0, 8'hF0, 8'h20, 0, 0, 8'h0F, 7);
    // R3 registered carry: 16-bit add then subtract over two cycles each
    step("R3 lo add", 3, 0, 8'hF0, 8'h20, 0, 0, 8'hFF, 7);
    step("R3 hi add", 3, 1, 8'h01, 8'h00, 0, 0, 8'hFF, 7);
    step("R3 lo sub", 4, 0, 8'h00, 8'h01, 0, 0, 8'hFF, 7);
    step("R3 hi sub", 4, 1, 8'h05, 8'h00, 0, 0, 8'hFF, 7);
    step("R8 logic clears flag", 5, 1, 8'h00, 8'h00, 0, 0, 8'hFF, 7);
    // R9 cascade
    cascade("add", 3, 16'h12FF, 16'h0001);
    cascade("add", 3, 16'hFFFF, 16'h0001);
    cascade("sub", 4, 16'h1200, 16'h0001);
    cascade("sub", 4, 16'h0000, 16'h0001);
    // reset mid-run: flag must clear
    step("R8 set flag", 1, 0, 8'hFF, 0, 0, 0, 8'hFF, 7);
    @(negedge clk); rst_n = 1'b0; #1;
    check("R8 async reset", int'(cflag), 0);
    exp_flag = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 2000; i++) begin
      int mk;
      mk = ($urandom % 4 == 0) ? int'($urandom % 256) : 255;
      cascade("rnd", ($urandom % 2) ? 3 : 4, int'($urandom % 65536), int'($urandom % 65536));
      step("rnd", int'($urandom % 8), int'($urandom % 4), int'($urandom % 256),
           int'($urandom % 256), int'($urandom % 2), int'($urandom % 2), mk,
           int'($urandom % 8));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule